// File: doc/BRIEF.md
# Chained Descriptor DMA Sequencer

This block walks a chain of 8-byte descriptors kept in system memory and turns each data descriptor into one address/length command for a downstream data mover. Software gives it the table base and a one-cycle start pulse. The sequencer reads one descriptor at a time over a simple request/acknowledge read port, decodes it and then takes one of three actions: it hands a segment to the mover and waits for completion, it jumps to a new table location, or it skips the entry. The chain stops at an entry that carries the end flag.

A single system-address register follows the walk. It is loaded with the base on start and afterwards always names the next descriptor to be read. When a run ends in an error, the sequencer raises a sticky error flag and records a 2-bit code that tells where the failure happened. The code also tells how the saved address must be read: after a fetch failure it points at the offending entry, and after a mover or stop failure it points at the entry that follows the offending one. The card protocol, the data FIFO and the actual data movement sit outside the block, behind the fetch and mover handshakes.

Top module: `sg_desc_dma`

## Requirements
- R1: After reset the block is idle (busy low), issues no fetch or mover request, holds err_irq low and err_code at 0, and holds sys_addr at 0.
- R2: A go pulse while idle loads tbl_base into sys_addr and starts a fetch at that address. The returned word is decoded as follows. fetch_data[7:0] is the attribute byte, with bit 0 valid, bit 1 end, bit 2 interrupt and bits 5:4 action. fetch_data[15:8] is reserved. fetch_data[31:16] is the length and fetch_data[63:32] is the pointer.
- R3: A valid entry with action 2'b10 (data) and non-zero length issues exactly one mover command carrying the pointer and the length. The command is held stable until mv_ack. After a clean completion without end, the next fetch is at the entry address + 8.
- R4: A valid entry with action 2'b11 (link) and no end flag issues no command, and the next fetch is at its pointer field.
- R5: Entries with action 2'b00 or 2'b01, and data entries with length 0, issue no command, and the walk moves on by 8 bytes.
- R6: An entry with the end flag finishes the run once it has been processed. For a data entry this is after its mv_ack. The block then gives a one-cycle xfer_done and drops busy, and sys_addr equals the end entry's address + 8. An end flag on a link entry is not followed.
- R7: An entry with the interrupt flag gives a one-cycle seg_irq when it completes. On a final data entry, seg_irq falls in the same cycle as xfer_done.
- R8: Any of the following is a fetch-state error: fetch_err set with fetch_ack, the valid bit clear, non-zero reserved bits (fetch_data[15:8], bit 3, bits 7:6), or a data length that is not a multiple of 4 or exceeds 65532. The error sets err_code = 1, leaves sys_addr at the faulty entry and issues no command.
- R9: mv_err set with mv_ack is a transfer-state error. It sets err_code = 3 and leaves sys_addr at the entry after the failed data entry.
- R10: If MAX_HOPS entries are processed without an end flag, the run stops with err_code = 0 and sys_addr at the entry after the last one. An end flag on the MAX_HOPS-th entry completes normally.
- R11: Every error sets err_irq, drops busy and gives no xfer_done. err_irq stays high until the next accepted go clears it.
- R12: A go pulse while busy is ignored. The running chain and its final sys_addr are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, accepted only while idle |
| tbl_base | input | AW | Descriptor table base address |
| busy | output | 1 | Chain walk in progress |
| sys_addr | output | AW | Address of the next descriptor to be read |
| fetch_req | output | 1 | Descriptor read request, held until fetch_ack |
| fetch_addr | output | AW | Descriptor read address |
| fetch_ack | input | 1 | Read completion, qualifies fetch_data and fetch_err |
| fetch_err | input | 1 | Bus error on the descriptor read |
| fetch_data | input | 64 | Descriptor word |
| mv_req | output | 1 | Segment command, held until mv_ack |
| mv_addr | output | AW | Segment address |
| mv_len | output | 16 | Segment length in bytes |
| mv_ack | input | 1 | Segment completion |
| mv_err | input | 1 | Segment failed, qualified by mv_ack |
| seg_irq | output | 1 | One-cycle descriptor interrupt pulse |
| xfer_done | output | 1 | One-cycle chain completion pulse |
| err_irq | output | 1 | Sticky error flag |
| err_code | output | 2 | Failing state: 0 stop, 1 fetch, 3 transfer |

## Verification
Two pairs of decisions can land on the same clock edge. In the first, the end flag sits on exactly the MAX_HOPS-th entry, so the end check and the hop limit fire together. The bench builds a chain of fifteen skip entries followed by an end entry and expects a clean finish with no error. It then removes the end flag and expects a stop-state error at 0x80. In the second, a final data entry carries both the end and interrupt flags. The bench counts the cycles where seg_irq and xfer_done are both high and expects exactly one. A chain that ends on a separate end entry without the interrupt flag must show none.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_FETCH = 2'd1,
      SEQ_MOVE  = 2'd2
   } seq_t;

   typedef enum logic [1:0] {
      ACT_NOP  = 2'b00,
      ACT_RSV  = 2'b01,
      ACT_DATA = 2'b10,
      ACT_LINK = 2'b11
   } act_t;

   localparam logic [1:0] EC_STOP  = 2'd0;
   localparam logic [1:0] EC_FETCH = 2'd1;
   localparam logic [1:0] EC_MOVE  = 2'd3;

   localparam int DESC_BYTES = 8;

   typedef struct packed {
      logic        valid;
      logic        last;
      logic        irq;
      act_t        act;
      logic [15:0] len;
      logic [31:0] ptr;
   } desc_t;

endpackage

// File: rtl/cdma_desc_dec.sv
module cdma_desc_dec
   import cdma_pkg::*;
#(
   parameter int MAX_LEN = 65532,
   parameter int ALIGN   = 4
) (
   input  logic [63:0] raw,
   output desc_t       d,
   output logic        malformed
);
   localparam int ALIGN_W = $clog2(ALIGN);

   generate
      if (MAX_LEN < 1 || MAX_LEN > 65535) begin : g_bad_len
         $error("cdma_desc_dec: MAX_LEN out of range");
      end
      if ((1 << ALIGN_W) != ALIGN) begin : g_bad_align
         $error("cdma_desc_dec: ALIGN must be a power of two");
      end
   endgenerate

   logic mis;
   logic rsvd_set;
   logic len_bad;

   generate
      if (ALIGN_W == 0) begin : g_no_align
         assign mis = 1'b0;
      end else begin : g_align
         assign mis = |raw[16 +: ALIGN_W];
      end
   endgenerate

   always_comb begin
      d.valid = raw[0];
      d.last  = raw[1];
      d.irq   = raw[2];
      d.act   = act_t'(raw[5:4]);
      d.len   = raw[31:16];
      d.ptr   = raw[63:32];
   end

   assign rsvd_set  = raw[3] | (|raw[7:6]) | (|raw[15:8]);
   assign len_bad   = (d.act == ACT_DATA) && (mis || (32'(d.len) > MAX_LEN));
   assign malformed = rsvd_set | len_bad;

endmodule

// File: rtl/cdma_hop_cnt.sv
module cdma_hop_cnt #(
   parameter int MAX_HOPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   generate
      if (MAX_HOPS < 0) begin : g_bad
         $error("cdma_hop_cnt: MAX_HOPS must not be negative");
      end
      if (MAX_HOPS == 0) begin : g_unlimited
         assign last = 1'b0;
      end else begin : g_limited
         localparam int CW = $clog2(MAX_HOPS + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (clr) cnt <= '0;
            else if (inc) cnt <= cnt + CW'(1);
         end
         assign last = (cnt == CW'(MAX_HOPS - 1));
      end
   endgenerate

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
   import cdma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] tbl_base,
   input  logic          fetch_ack,
   input  logic          fetch_err,
   input  desc_t         d,
   input  logic          malformed,
   input  logic          mv_ack,
   input  logic          mv_err,
   input  logic          hop_last,
   output logic          hop_clr,
   output logic          hop_inc,
   output logic          busy,
   output logic          fetch_req,
   output logic [AW-1:0] sys_addr,
   output logic          mv_req,
   output logic [AW-1:0] mv_addr,
   output logic [15:0]   mv_len,
   output logic          seg_irq,
   output logic          xfer_done,
   output logic          err_irq,
   output logic [1:0]    err_code
);
   localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

   seq_t st;
   logic pend_irq;
   logic pend_last;
   logic pend_lim;
   logic bad_fetch;
   logic issue;

   assign bad_fetch = fetch_err | ~d.valid | malformed;
   assign issue     = (d.act == ACT_DATA) && (d.len != 16'd0);

   assign busy      = (st != SEQ_IDLE);
   assign fetch_req = (st == SEQ_FETCH);
   assign mv_req    = (st == SEQ_MOVE);
   assign hop_clr   = (st == SEQ_IDLE) && go;
   assign hop_inc   = (st == SEQ_FETCH) && fetch_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SEQ_IDLE;
         sys_addr  <= '0;
         mv_addr   <= '0;
         mv_len    <= '0;
         pend_irq  <= 1'b0;
         pend_last <= 1'b0;
         pend_lim  <= 1'b0;
         seg_irq   <= 1'b0;
         xfer_done <= 1'b0;
         err_irq   <= 1'b0;
         err_code  <= EC_STOP;
      end else begin
         seg_irq   <= 1'b0;
         xfer_done <= 1'b0;
         case (st)
            SEQ_IDLE: begin
               if (go) begin
                  sys_addr <= tbl_base;
                  err_irq  <= 1'b0;
                  err_code <= EC_STOP;
                  st       <= SEQ_FETCH;
               end
            end
            SEQ_FETCH: begin
               if (fetch_ack) begin
                  if (bad_fetch) begin
                     err_irq  <= 1'b1;
                     err_code <= EC_FETCH;
                     st       <= SEQ_IDLE;
                  end else if (issue) begin
                     mv_addr   <= AW'(d.ptr);
                     mv_len    <= d.len;
                     sys_addr  <= sys_addr + STEP;
                     pend_irq  <= d.irq;
                     pend_last <= d.last;
                     pend_lim  <= hop_last;
                     st        <= SEQ_MOVE;
                  end else begin
                     seg_irq <= d.irq;
                     if (d.act == ACT_LINK && !d.last) sys_addr <= AW'(d.ptr);
                     else                              sys_addr <= sys_addr + STEP;
                     if (d.last) begin
                        xfer_done <= 1'b1;
                        st        <= SEQ_IDLE;
                     end else if (hop_last) begin
                        err_irq  <= 1'b1;
                        err_code <= EC_STOP;
                        st       <= SEQ_IDLE;
                     end
                  end
               end
            end
            SEQ_MOVE: begin
               if (mv_ack) begin
                  if (mv_err) begin
                     err_irq  <= 1'b1;
                     err_code <= EC_MOVE;
                     st       <= SEQ_IDLE;
                  end else begin
                     seg_irq <= pend_irq;
                     if (pend_last) begin
                        xfer_done <= 1'b1;
                        st        <= SEQ_IDLE;
                     end else if (pend_lim) begin
                        err_irq  <= 1'b1;
                        err_code <= EC_STOP;
                        st       <= SEQ_IDLE;
                     end else begin
                        st <= SEQ_FETCH;
                     end
                  end
               end
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sg_desc_dma.sv
module sg_desc_dma
   import cdma_pkg::*;
#(
   parameter int AW       = 32,
   parameter int MAX_HOPS = 16,
   parameter int MAX_LEN  = 65532,
   parameter int ALIGN    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] tbl_base,
   output logic          busy,
   output logic [AW-1:0] sys_addr,
   output logic          fetch_req,
   output logic [AW-1:0] fetch_addr,
   input  logic          fetch_ack,
   input  logic          fetch_err,
   input  logic [63:0]   fetch_data,
   output logic          mv_req,
   output logic [AW-1:0] mv_addr,
   output logic [15:0]   mv_len,
   input  logic          mv_ack,
   input  logic          mv_err,
   output logic          seg_irq,
   output logic          xfer_done,
   output logic          err_irq,
   output logic [1:0]    err_code
);
   generate
      if (AW < 32 || AW > 64) begin : g_bad_aw
         $error("sg_desc_dma: AW must lie in 32..64");
      end
   endgenerate

   desc_t d;
   logic  malformed;
   logic  hop_clr;
   logic  hop_inc;
   logic  hop_last;

   cdma_desc_dec #(.MAX_LEN(MAX_LEN), .ALIGN(ALIGN)) u_dec (
      .raw       (fetch_data),
      .d         (d),
      .malformed (malformed)
   );

   cdma_hop_cnt #(.MAX_HOPS(MAX_HOPS)) u_hops (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (hop_clr),
      .inc   (hop_inc),
      .last  (hop_last)
   );

   cdma_seq #(.AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .tbl_base  (tbl_base),
      .fetch_ack (fetch_ack),
      .fetch_err (fetch_err),
      .d         (d),
      .malformed (malformed),
      .mv_ack    (mv_ack),
      .mv_err    (mv_err),
      .hop_last  (hop_last),
      .hop_clr   (hop_clr),
      .hop_inc   (hop_inc),
      .busy      (busy),
      .fetch_req (fetch_req),
      .sys_addr  (sys_addr),
      .mv_req    (mv_req),
      .mv_addr   (mv_addr),
      .mv_len    (mv_len),
      .seg_irq   (seg_irq),
      .xfer_done (xfer_done),
      .err_irq   (err_irq),
      .err_code  (err_code)
   );

   assign fetch_addr = sys_addr;

endmodule

// File: rtl/sg_desc_dma_chk.sv
module sg_desc_dma_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          fetch_req,
   input logic          fetch_ack,
   input logic [AW-1:0] fetch_addr,
   input logic          mv_req,
   input logic          mv_ack,
   input logic [AW-1:0] mv_addr,
   input logic [15:0]   mv_len,
   input logic          xfer_done,
   input logic          err_irq,
   input logic [1:0]    err_code
);
   // R3: a segment command stays put until the mover takes it
   a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_req && !mv_ack) |=> (mv_req && $stable(mv_addr) && $stable(mv_len)));

   // R2: a descriptor read stays put until acknowledged
   a_r2_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

   // R3: never reading a descriptor and moving a segment at once
   a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && mv_req));

   // R6: completion is reported with the block already idle
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !busy);

   // R11: an error never coincides with a completion
   a_r11_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_irq) |-> (!xfer_done && !busy));

   // R8: code 2 is never reported
   a_r8_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> (err_code != 2'd2));
endmodule

bind sg_desc_dma sg_desc_dma_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .fetch_req  (fetch_req),
   .fetch_ack  (fetch_ack),
   .fetch_addr (fetch_addr),
   .mv_req     (mv_req),
   .mv_ack     (mv_ack),
   .mv_addr    (mv_addr),
   .mv_len     (mv_len),
   .xfer_done  (xfer_done),
   .err_irq    (err_irq),
   .err_code   (err_code)
);

// File: tb/sim_sg_desc_dma.sv
`timescale 1ns/1ps
module sim_sg_desc_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        busy;
   logic [31:0] sys_addr;
   logic        fetch_req;
   logic [31:0] fetch_addr;
   logic        fetch_ack = 1'b0;
   logic        fetch_err = 1'b0;
   logic [63:0] fetch_data = '0;
   logic        mv_req;
   logic [31:0] mv_addr;
   logic [15:0] mv_len;
   logic        mv_ack = 1'b0;
   logic        mv_err = 1'b0;
   logic        seg_irq;
   logic        xfer_done;
   logic        err_irq;
   logic [1:0]  err_code;

   sg_desc_dma u0 (.*);

   initial forever #2.5 clk = ~clk;

   logic [63:0] mem [0:63];
   logic [31:0] lg_addr [0:31];
   logic [15:0] lg_len  [0:31];
   int checks = 0, errors = 0;
   int ncmd = 0, ndone = 0, nseg = 0, ncoinc = 0;
   int fetch_lat = 0, mv_lat = 0, err_seg = -1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input bit v, input bit e, input bit i,
                                      input logic [1:0] act, input logic [15:0] len,
                                      input logic [31:0] ptr);
      return {ptr, len, 8'h00, 2'b00, act, 1'b0, i, e, v};
   endfunction

   task automatic clear_mem();
      for (int k = 0; k < 64; k++) mem[k] = '0;
   endtask

   // descriptor memory: addresses 0..511 valid, beyond is a bus error
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (fetch_ack) begin
            fetch_ack = 1'b0; fetch_err = 1'b0; cnt = 0;
         end else if (fetch_req) begin
            if (cnt >= fetch_lat) begin
               fetch_data = mem[fetch_addr[8:3]];
               fetch_err  = (fetch_addr >= 32'd512);
               fetch_ack  = 1'b1;
               cnt = 0;
            end else cnt++;
         end
      end
   end

   // data mover model
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (mv_ack) begin
            mv_ack = 1'b0; mv_err = 1'b0; cnt = 0;
         end else if (mv_req) begin
            if (cnt >= mv_lat) begin
               if (ncmd < 32) begin lg_addr[ncmd] = mv_addr; lg_len[ncmd] = mv_len; end
               mv_err = (ncmd == err_seg);
               mv_ack = 1'b1;
               ncmd++;
               cnt = 0;
            end else cnt++;
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (xfer_done) ndone++;
      if (seg_irq) nseg++;
      if (seg_irq && xfer_done) ncoinc++;
   end

   task automatic launch(input logic [31:0] base);
      ncmd = 0; ndone = 0; nseg = 0; ncoinc = 0;
      @(negedge clk); tbl_base = base; go = 1'b1;
      @(negedge clk); go = 1'b0;
   endtask

   task automatic finish_run();
      int w = 0;
      while (busy && w < 4000) begin @(negedge clk); w++; end
      if (busy) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual busy 1 expected 0");
      end
      @(negedge clk);
   endtask

   task automatic run(input logic [31:0] base);
      launch(base);
      finish_run();
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: global timeout, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", busy, 0);
      check("R1 fetch_req", fetch_req, 0);
      check("R1 mv_req", mv_req, 0);
      check("R1 err_irq", err_irq, 0);
      check("R1 err_code", err_code, 0);
      check("R1 sys_addr", sys_addr, 0);

      // R3/R6/R7 sweep: n data entries, end on last or on a separate entry
      for (int lat = 0; lat < 3; lat++) begin
         for (int n = 1; n <= 5; n++) begin
            for (int term = 0; term < 2; term++) begin
               clear_mem();
               fetch_lat = lat; mv_lat = 2 - lat;
               for (int k = 0; k < n; k++)
                  mem[8 + k] = mk(1, (term == 0) && (k == n - 1), 1, 2'b10,
                                  16'(12 * (k + 1)), 32'(32'h1000 * (k + 1) + 4 * k));
               if (term == 1) mem[8 + n] = mk(1, 1, 0, 2'b00, 16'd0, 32'd0);
               run(32'h40);
               check("R3 cmd count", ncmd, n);
               for (int k = 0; k < n; k++) begin
                  check("R3 cmd addr", lg_addr[k], 32'h1000 * (k + 1) + 4 * k);
                  check("R3 cmd len", 32'(lg_len[k]), 12 * (k + 1));
               end
               check("R6 done", ndone, 1);
               check("R6 sys_addr", sys_addr, 32'h40 + 8 * (n + term));
               check("R7 seg_irq count", nseg, n);
               check("R7 coincidence", ncoinc, (term == 0) ? 1 : 0);
               check("R11 no err", err_irq, 0);
            end
         end
      end
      fetch_lat = 1; mv_lat = 1;

      // R4 link
      clear_mem();
      mem[0]  = mk(1, 0, 0, 2'b10, 16'd8, 32'h2000);
      mem[1]  = mk(1, 0, 0, 2'b11, 16'd0, 32'h100);
      mem[32] = mk(1, 1, 0, 2'b10, 16'd16, 32'h3000);
      run(32'h0);
      check("R4 cmds", ncmd, 2);
      check("R4 target addr", lg_addr[1], 32'h3000);
      check("R4 sys_addr", sys_addr, 32'h108);

      // R6 end on link is not followed
      clear_mem();
      mem[0] = mk(1, 1, 0, 2'b11, 16'd0, 32'h180);
      run(32'h0);
      check("R6 link end done", ndone, 1);
      check("R6 link end sys_addr", sys_addr, 32'h8);
      check("R6 link end cmds", ncmd, 0);

      // R5 skips and zero length, R7 irq on skipped entries
      clear_mem();
      mem[0] = mk(1, 0, 1, 2'b00, 16'd4, 32'h500);
      mem[1] = mk(1, 0, 1, 2'b01, 16'd4, 32'h600);
      mem[2] = mk(1, 0, 0, 2'b10, 16'd0, 32'h700);
      mem[3] = mk(1, 1, 0, 2'b10, 16'd4, 32'h40);
      run(32'h0);
      check("R5 cmds", ncmd, 1);
      check("R5 cmd addr", lg_addr[0], 32'h40);
      check("R7 skip irqs", nseg, 2);
      check("R5 sys_addr", sys_addr, 32'h20);

      // R8 invalid entry
      clear_mem();
      mem[0] = mk(1, 0, 0, 2'b10, 16'd4, 32'h80);
      run(32'h0);
      check("R8 invalid code", err_code, 1);
      check("R8 invalid sys_addr", sys_addr, 32'h8);
      check("R8 cmds before", ncmd, 1);
      check("R11 err_irq", err_irq, 1);
      check("R11 no done", ndone, 0);

      // R8 misaligned and oversize lengths
      clear_mem();
      mem[0] = mk(1, 1, 0, 2'b10, 16'd6, 32'h80);
      run(32'h0);
      check("R8 misaligned code", err_code, 1);
      check("R8 misaligned cmds", ncmd, 0);
      mem[0] = mk(1, 1, 0, 2'b10, 16'd65535, 32'h80);
      run(32'h0);
      check("R8 oversize code", err_code, 1);
      check("R8 oversize sys_addr", sys_addr, 32'h0);

      // R8 reserved byte set
      clear_mem();
      mem[0] = mk(1, 1, 0, 2'b10, 16'd4, 32'h80) | 64'h0000_0000_0000_5A00;
      run(32'h0);
      check("R8 reserved code", err_code, 1);
      check("R8 reserved cmds", ncmd, 0);

      // R8 bus error via link to unmapped area
      clear_mem();
      mem[0] = mk(1, 0, 0, 2'b11, 16'd0, 32'h400);
      run(32'h0);
      check("R8 bus err code", err_code, 1);
      check("R8 bus err sys_addr", sys_addr, 32'h400);

      // R9 mover error on second segment
      clear_mem();
      for (int k = 0; k < 3; k++) mem[16 + k] = mk(1, k == 2, 0, 2'b10, 16'd4, 32'(k * 64));
      err_seg = 1;
      run(32'h80);
      err_seg = -1;
      check("R9 code", err_code, 3);
      check("R9 sys_addr", sys_addr, 32'h90);
      check("R9 cmds", ncmd, 2);
      check("R9 no done", ndone, 0);

      // R11 next go clears err_irq
      run(32'h80);
      check("R11 cleared", err_irq, 0);
      check("R11 done after clear", ndone, 1);

      // R10 hop limit vs end on the same entry
      clear_mem();
      for (int k = 0; k < 16; k++) mem[k] = mk(1, k == 15, 0, 2'b00, 16'd0, 32'd0);
      run(32'h0);
      check("R10 end wins", ndone, 1);
      check("R10 end wins err", err_irq, 0);
      check("R10 end wins sys_addr", sys_addr, 32'h80);
      mem[15] = mk(1, 0, 0, 2'b00, 16'd0, 32'd0);
      run(32'h0);
      check("R10 stop code", err_code, 0);
      check("R10 stop err", err_irq, 1);
      check("R10 stop sys_addr", sys_addr, 32'h80);

      // R10 limit reached on data entries
      clear_mem();
      for (int k = 0; k < 16; k++) mem[k] = mk(1, 0, 0, 2'b10, 16'd4, 32'(k * 16));
      run(32'h0);
      check("R10 data cmds", ncmd, 16);
      check("R10 data err", err_irq, 1);
      check("R10 data code", err_code, 0);
      check("R10 data sys_addr", sys_addr, 32'h80);

      // R12 go while busy is ignored
      clear_mem();
      mem[0] = mk(1, 0, 0, 2'b10, 16'd4, 32'h10);
      mem[1] = mk(1, 1, 0, 2'b10, 16'd4, 32'h20);
      mv_lat = 20;
      launch(32'h0);
      repeat (4) @(negedge clk);
      tbl_base = 32'h1F0; go = 1'b1;
      @(negedge clk); go = 1'b0;
      finish_run();
      mv_lat = 1;
      check("R12 cmds", ncmd, 2);
      check("R12 sys_addr", sys_addr, 32'h10);
      check("R12 done", ndone, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule